// File: doc/BRIEF.md
# Exception Entry/Return Sequencer

This block paces the control side of exception handling in a small core. An external arbiter offers an exception (number plus priority) on `take_i`; the sequencer then runs a fixed-length register save phase (one push beat per saved core register) and a vector fetch phase before the handler starts. When the running handler signals completion on `ret_i`, the sequencer either restores context through a pop phase or, when the arbiter is offering something with enough priority, chains straight into the next handler through a short fixed-length transition. No memory traffic or register data is modelled; only the timing, the target exception number and the beat strobes leave the block.

Two latency optimisations are modelled. A more urgent offer that arrives while the entry sequence is still running replaces the vector target without restarting or stretching the save. The target it displaced is remembered, and when the late handler returns, control chains to that displaced exception instead of unstacking. A more urgent offer while a handler runs is ordinary preemption: the running context is pushed on a small nesting stack and a full entry runs; its eventual return unstacks back into the preempted handler.

Top module: `exc_seq`

## Requirements
- R1: After reset `state_o` is 0 (idle), `cyc_o` is 0, `vec_num_o` is 0 and `push_o`, `pop_o`, `busy_o` are low. State codes: 0 idle, 1 stacking, 2 vector fetch, 3 handler running, 4 unstacking, 5 tail-chain.
- R2: A `take_i` seen in idle starts entry: stacking is visible for 8 cycles with `push_o` high in each, then vector fetch for 4 cycles, so 12 cycles elapse before state 3; `cyc_o` counts 1 to 12 over those cycles and `vec_num_o` equals the offered number from the first stacking cycle.
- R3: `busy_o` is high exactly in the stacking and unstacking states.
- R4: A `ret_i` in state 3 without a chain condition and without late-arrival history gives 10 cycles of unstacking with `pop_o` high in the first 8 of them (`cyc_o` 1 to 10), then idle when no preempted handler is nested.
- R5: A `ret_i` in state 3 with `take_i` high, when nothing is nested or the offered priority value is strictly below that of the nested handler, gives 6 cycles of state 5 (`cyc_o` 1 to 6) with no push or pop beat and `busy_o` low, `vec_num_o` showing the new number, then state 3.
- R6: During stacking or vector fetch, a `take_i` whose priority value is strictly below that of the current target replaces `vec_num_o` from the next cycle, leaving state, `cyc_o` and the push beats unchanged.
- R7: During stacking or vector fetch, a `take_i` whose priority value is equal to or above that of the current target has no effect.
- R8: On `ret_i` from a handler that arrived late, the sequencer tail-chains (R5 timing) to the displaced exception, unless the offer meets the R5 condition and is also strictly more urgent than the displaced one, in which case it chains to the offer.
- R9: In state 3, a `take_i` strictly more urgent than the running handler (and no `ret_i`) starts a full R2 entry and nests the running handler; when the preempting handler later unstacks, state 3 resumes with the preempted number.
- R10: On `ret_i` from a nested handler, an offer that is not strictly more urgent than the nested handler does not chain; a full unstack follows.
- R11: `ret_i` outside state 3 is ignored; `take_i` during unstacking or tail-chain is ignored; `take_i` in state 3 not strictly more urgent than the running handler is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| take_i | input | 1 | Arbiter offers an exception this cycle |
| take_num_i | input | NUM_W | Offered exception number |
| take_prio_i | input | PRIO_W | Offered priority, lower value is more urgent |
| ret_i | input | 1 | Running handler completes |
| state_o | output | 3 | Sequencer state code |
| cyc_o | output | CW | Cycles consumed in the current transition, 0 outside one |
| vec_num_o | output | NUM_W | Exception being vectored to or running |
| push_o | output | 1 | Register save beat |
| pop_o | output | 1 | Register restore beat |
| busy_o | output | 1 | Stacking or unstacking in progress |

## Verification
The assertions take for granted that the arbiter never preempts when the nesting stack already holds its full depth, so a nest push never meets a full stack; pops are only issued with a non-empty stack by design. The stimulus never nests more than one handler, and every late or preempting offer is chosen with a known priority relation to the current and nested handlers, so each branch of the return decision is reached on purpose. Phase-length assertions rely on the transition counter moving one step per cycle, which holds as long as no reset occurs mid-sequence.

// File: rtl/exc_seq_pkg.sv
`timescale 1ns/1ps
package exc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_STACK = 3'd1,
    ST_VEC   = 3'd2,
    ST_RUN   = 3'd3,
    ST_UNSTK = 3'd4,
    ST_TAIL  = 3'd5
  } seq_state_e;
endpackage

// File: rtl/exc_seq_cyc_ctr.sv
`timescale 1ns/1ps
module exc_seq_cyc_ctr #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          step_i,
  input  logic          clr_i,
  output logic [CW-1:0] cyc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cyc_o <= '0;
    else if (clr_i)   cyc_o <= '0;
    else if (start_i) cyc_o <= CW'(1);
    else if (step_i)  cyc_o <= cyc_o + CW'(1);
  end
endmodule

// File: rtl/exc_seq_target.sv
`timescale 1ns/1ps
module exc_seq_target #(
  parameter int NW = 8,
  parameter int PW = 4,
  localparam int FW = 1 + 2 * (NW + PW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          late_i,
  input  logic          chain_i,
  input  logic          restore_i,
  input  logic [NW-1:0] new_num_i,
  input  logic [PW-1:0] new_prio_i,
  input  logic [NW-1:0] chain_num_i,
  input  logic [PW-1:0] chain_prio_i,
  input  logic [FW-1:0] frame_i,
  output logic [NW-1:0] cur_num_o,
  output logic [PW-1:0] cur_prio_o,
  output logic          late_o,
  output logic [NW-1:0] disp_num_o,
  output logic [PW-1:0] disp_prio_o,
  output logic [FW-1:0] frame_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_num_o   <= '0;
      cur_prio_o  <= '0;
      late_o      <= 1'b0;
      disp_num_o  <= '0;
      disp_prio_o <= '0;
    end else if (load_i) begin
      cur_num_o  <= new_num_i;
      cur_prio_o <= new_prio_i;
      late_o     <= 1'b0;
    end else if (late_i) begin
      disp_num_o  <= cur_num_o;
      disp_prio_o <= cur_prio_o;
      cur_num_o   <= new_num_i;
      cur_prio_o  <= new_prio_i;
      late_o      <= 1'b1;
    end else if (chain_i) begin
      cur_num_o  <= chain_num_i;
      cur_prio_o <= chain_prio_i;
      late_o     <= 1'b0;
    end else if (restore_i) begin
      {late_o, disp_num_o, disp_prio_o, cur_num_o, cur_prio_o} <= frame_i;
    end
  end

  assign frame_o = {late_o, disp_num_o, disp_prio_o, cur_num_o, cur_prio_o};

  // R6: the sequencer issues at most one target command per cycle
  assert_one_cmd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({load_i, late_i, chain_i, restore_i}));

  // R6: a late swap always moves to a strictly more urgent target
  assert_late_urgent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_i |=> (late_o && cur_prio_o < $past(cur_prio_o)));
endmodule

// File: rtl/exc_seq_nest.sv
`timescale 1ns/1ps
module exc_seq_nest #(
  parameter int DEPTH = 4,
  parameter int EW    = 25,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [EW-1:0] din_i,
  output logic [EW-1:0] top_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [EW-1:0]   mem_q [DEPTH];
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (push_i) cnt_q <= cnt_q + CNTW'(1);
    else if (pop_i)  cnt_q <= cnt_q - CNTW'(1);
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[AW'(cnt_q)] <= din_i;
  end

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNTW'(DEPTH));
  assign top_o   = empty_o ? '0 : mem_q[AW'(cnt_q - CNTW'(1))];

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_no_pushpop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));
endmodule

// File: rtl/exc_seq.sv
`timescale 1ns/1ps
module exc_seq
  import exc_seq_pkg::*;
#(
  parameter int NUM_W      = 8,
  parameter int PRIO_W     = 4,
  parameter int N_REGS     = 8,
  parameter int VEC_CYC    = 4,
  parameter int UNSTK_CYC  = 10,
  parameter int TAIL_CYC   = 6,
  parameter int NEST_DEPTH = 4,
  localparam int ENTRY_CYC = N_REGS + VEC_CYC,
  localparam int MAX_CYC   = (ENTRY_CYC > UNSTK_CYC) ?
                             ((ENTRY_CYC > TAIL_CYC) ? ENTRY_CYC : TAIL_CYC) :
                             ((UNSTK_CYC > TAIL_CYC) ? UNSTK_CYC : TAIL_CYC),
  localparam int CW        = $clog2(MAX_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [NUM_W-1:0]  take_num_i,
  input  logic [PRIO_W-1:0] take_prio_i,
  input  logic              ret_i,
  output logic [2:0]        state_o,
  output logic [CW-1:0]     cyc_o,
  output logic [NUM_W-1:0]  vec_num_o,
  output logic              push_o,
  output logic              pop_o,
  output logic              busy_o
);
  localparam int FW = 1 + 2 * (NUM_W + PRIO_W);
  localparam logic [CW-1:0] STK_END = CW'(N_REGS);
  localparam logic [CW-1:0] ENT_END = CW'(ENTRY_CYC);
  localparam logic [CW-1:0] UNS_END = CW'(UNSTK_CYC);
  localparam logic [CW-1:0] TAI_END = CW'(TAIL_CYC);

  seq_state_e state_q, state_d;
  logic [CW-1:0] cyc;
  logic cyc_start, cyc_step, cyc_clr;
  logic tg_load, tg_late, tg_chain, tg_restore;
  logic nest_push, nest_pop, nest_empty, nest_full;
  logic [FW-1:0] nest_top, cur_frame;
  logic [NUM_W-1:0]  cur_num, disp_num, chain_num;
  logic [PRIO_W-1:0] cur_prio, disp_prio, chain_prio, top_prio;
  logic late, take_ok, urgent;

  assign top_prio = nest_top[PRIO_W-1:0];
  assign urgent   = take_i && (take_prio_i < cur_prio);
  // offer outranks whatever the return would go back to
  assign take_ok  = take_i && (nest_empty || take_prio_i < top_prio);

  always_comb begin
    state_d    = state_q;
    cyc_start  = 1'b0;
    cyc_step   = 1'b0;
    cyc_clr    = 1'b0;
    tg_load    = 1'b0;
    tg_late    = 1'b0;
    tg_chain   = 1'b0;
    tg_restore = 1'b0;
    nest_push  = 1'b0;
    nest_pop   = 1'b0;
    chain_num  = take_num_i;
    chain_prio = take_prio_i;
    unique case (state_q)
      ST_IDLE: begin
        if (take_i) begin
          state_d   = ST_STACK;
          cyc_start = 1'b1;
          tg_load   = 1'b1;
        end
      end
      ST_STACK, ST_VEC: begin
        tg_late = urgent;
        if (state_q == ST_VEC && cyc == ENT_END) begin
          state_d = ST_RUN;
          cyc_clr = 1'b1;
        end else begin
          cyc_step = 1'b1;
          if (state_q == ST_STACK && cyc == STK_END) state_d = ST_VEC;
        end
      end
      ST_RUN: begin
        if (ret_i) begin
          if (late) begin
            state_d   = ST_TAIL;
            cyc_start = 1'b1;
            tg_chain  = 1'b1;
            if (!(take_ok && take_prio_i < disp_prio)) begin
              chain_num  = disp_num;
              chain_prio = disp_prio;
            end
          end else if (take_ok) begin
            state_d   = ST_TAIL;
            cyc_start = 1'b1;
            tg_chain  = 1'b1;
          end else begin
            state_d   = ST_UNSTK;
            cyc_start = 1'b1;
          end
        end else if (urgent) begin
          state_d   = ST_STACK;
          cyc_start = 1'b1;
          tg_load   = 1'b1;
          nest_push = 1'b1;
        end
      end
      ST_UNSTK: begin
        if (cyc == UNS_END) begin
          cyc_clr = 1'b1;
          if (!nest_empty) begin
            state_d    = ST_RUN;
            nest_pop   = 1'b1;
            tg_restore = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end else begin
          cyc_step = 1'b1;
        end
      end
      ST_TAIL: begin
        if (cyc == TAI_END) begin
          state_d = ST_RUN;
          cyc_clr = 1'b1;
        end else begin
          cyc_step = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  exc_seq_cyc_ctr #(.CW(CW)) u_cyc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cyc_start),
    .step_i  (cyc_step),
    .clr_i   (cyc_clr),
    .cyc_o   (cyc)
  );

  exc_seq_target #(.NW(NUM_W), .PW(PRIO_W)) u_target (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (tg_load),
    .late_i       (tg_late),
    .chain_i      (tg_chain),
    .restore_i    (tg_restore),
    .new_num_i    (take_num_i),
    .new_prio_i   (take_prio_i),
    .chain_num_i  (chain_num),
    .chain_prio_i (chain_prio),
    .frame_i      (nest_top),
    .cur_num_o    (cur_num),
    .cur_prio_o   (cur_prio),
    .late_o       (late),
    .disp_num_o   (disp_num),
    .disp_prio_o  (disp_prio),
    .frame_o      (cur_frame)
  );

  exc_seq_nest #(.DEPTH(NEST_DEPTH), .EW(FW)) u_nest (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (nest_push),
    .pop_i   (nest_pop),
    .din_i   (cur_frame),
    .top_o   (nest_top),
    .empty_o (nest_empty),
    .full_o  (nest_full)
  );

  assign state_o   = state_q;
  assign cyc_o     = cyc;
  assign vec_num_o = cur_num;
  assign push_o    = (state_q == ST_STACK);
  assign pop_o     = (state_q == ST_UNSTK) && (cyc <= STK_END);
  assign busy_o    = (state_q == ST_STACK) || (state_q == ST_UNSTK);

  assert_stack_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_VEC && $past(state_q) == ST_STACK) |-> $past(cyc) == STK_END);
  assert_entry_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && $past(state_q) == ST_VEC) |-> $past(cyc) == ENT_END);
  assert_unstk_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_UNSTK && $past(state_q) == ST_UNSTK) |-> $past(cyc) == UNS_END);
  assert_tail_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_TAIL && $past(state_q) == ST_TAIL) |-> $past(cyc) == TAI_END);
  assert_late_timing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tg_late && cyc != ENT_END) |=> cyc == CW'($past(cyc) + CW'(1)));
  assert_ret_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && state_q == ST_TAIL) |=> (state_q == ST_TAIL || state_q == ST_RUN));
  assert_nest_room_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nest_push |-> !nest_full);
endmodule

// File: tb/exc_seq_tb_top.sv
`timescale 1ns/1ps
module exc_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic take = 1'b0;
  logic [7:0] take_num = '0;
  logic [3:0] take_prio = '0;
  logic ret = 1'b0;
  logic [2:0] state_o;
  logic [3:0] cyc_o;
  logic [7:0] vec_num_o;
  logic push_o, pop_o, busy_o;

  always #4 clk = ~clk;

  exc_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .take_i(take), .take_num_i(take_num),
    .take_prio_i(take_prio), .ret_i(ret), .state_o(state_o), .cyc_o(cyc_o),
    .vec_num_o(vec_num_o), .push_o(push_o), .pop_o(pop_o), .busy_o(busy_o)
  );

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  // behavioural reference
  typedef struct { int num; int prio; int late; int dnum; int dprio; } frame_t;
  frame_t nq[$];
  frame_t fr;
  int m_st, m_cyc, m_vec, m_prio, m_late, m_dnum, m_dprio;
  bit tok;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cyc = 0; m_vec = 0; m_prio = 0; m_late = 0; m_dnum = 0; m_dprio = 0;
      nq.delete();
    end else begin
      tok = take && ((nq.size() == 0) ? 1'b1 : (int'(take_prio) < nq[nq.size()-1].prio));
      case (m_st)
        0: if (take) begin m_st = 1; m_cyc = 1; m_vec = take_num; m_prio = take_prio; m_late = 0; end
        1, 2: begin
          if (take && int'(take_prio) < m_prio) begin
            m_dnum = m_vec; m_dprio = m_prio; m_vec = take_num; m_prio = take_prio; m_late = 1;
          end
          if (m_st == 2 && m_cyc == 12) begin m_st = 3; m_cyc = 0; end
          else begin
            if (m_st == 1 && m_cyc == 8) m_st = 2;
            m_cyc++;
          end
        end
        3: begin
          if (ret) begin
            if (m_late == 1) begin
              if (tok && int'(take_prio) < m_dprio) begin m_vec = take_num; m_prio = take_prio; end
              else begin m_vec = m_dnum; m_prio = m_dprio; end
              m_late = 0; m_st = 5; m_cyc = 1;
            end else if (tok) begin
              m_vec = take_num; m_prio = take_prio; m_st = 5; m_cyc = 1;
            end else begin
              m_st = 4; m_cyc = 1;
            end
          end else if (take && int'(take_prio) < m_prio) begin
            fr.num = m_vec; fr.prio = m_prio; fr.late = m_late; fr.dnum = m_dnum; fr.dprio = m_dprio;
            nq.push_back(fr);
            m_vec = take_num; m_prio = take_prio; m_late = 0; m_st = 1; m_cyc = 1;
          end
        end
        4: begin
          if (m_cyc == 10) begin
            m_cyc = 0;
            if (nq.size() > 0) begin
              fr = nq.pop_back();
              m_vec = fr.num; m_prio = fr.prio; m_late = fr.late; m_dnum = fr.dnum; m_dprio = fr.dprio;
              m_st = 3;
            end else m_st = 0;
          end else m_cyc++;
        end
        5: begin
          if (m_cyc == 6) begin m_st = 3; m_cyc = 0; end
          else m_cyc++;
        end
        default: m_st = 0;
      endcase
    end
  end

  task automatic compare_all();
    int e_push, e_pop, e_busy;
    e_push = (m_st == 1);
    e_pop  = (m_st == 4 && m_cyc <= 8);
    e_busy = (m_st == 1 || m_st == 4);
    checks++;
    if (int'(state_o) != m_st || int'(cyc_o) != m_cyc || int'(vec_num_o) != m_vec ||
        int'(push_o) != e_push || int'(pop_o) != e_pop || int'(busy_o) != e_busy) begin
      fails++;
      $display("FAIL %s st/cyc/vec/push/pop/busy act %0d/%0d/%0d/%0d/%0d/%0d exp %0d/%0d/%0d/%0d/%0d/%0d",
               cur_req, state_o, cyc_o, vec_num_o, push_o, pop_o, busy_o,
               m_st, m_cyc, m_vec, e_push, e_pop, e_busy);
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic cyc1();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic pulse(input bit t, input int n, input int p, input bit r);
    take = t; take_num = 8'(n); take_prio = 4'(p); ret = r;
    cyc1();
    take = 1'b0; ret = 1'b0;
  endtask

  task automatic wait_st(input int s);
    while (int'(state_o) != s) cyc1();
  endtask

  // counts cycles spent in s1 or s2, starting with the current one
  task automatic span(input int s1, input int s2, output int n, output int np, output int npo, output int nb);
    n = 0; np = 0; npo = 0; nb = 0;
    while (int'(state_o) == s1 || int'(state_o) == s2) begin
      n++; np += push_o; npo += pop_o; nb += busy_o;
      cyc1();
    end
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      checks++; fails++;
      $display("FAIL %s watchdog act 1 exp 0", cur_req);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n, np, npo, nb;
    repeat (3) @(negedge clk);
    compare_all();
    rst_n = 1'b1;
    cyc1();
    cur_req = "R1";
    chk("R1 state", int'(state_o), 0);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 vec", int'(vec_num_o), 0);

    // plain entry and return
    cur_req = "R2";
    pulse(1, 20, 5, 0);
    span(1, 2, n, np, npo, nb);
    chk("R2 entry cycles", n, 12);
    chk("R2 push beats", np, 8);
    chk("R3 busy during entry", nb, 8);
    chk("R2 vec", int'(vec_num_o), 20);
    cur_req = "R11";
    pulse(1, 40, 9, 0);
    chk("R11 less urgent in run", int'(state_o), 3);
    cyc1();
    cur_req = "R4";
    pulse(0, 0, 0, 1);
    span(4, 4, n, np, npo, nb);
    chk("R4 unstack cycles", n, 10);
    chk("R4 pop beats", npo, 8);
    chk("R3 busy during unstack", nb, 10);
    chk("R4 idle after", int'(state_o), 0);
    cur_req = "R11";
    pulse(0, 0, 0, 1);
    chk("R11 ret in idle", int'(state_o), 0);

    // late arrival during stacking, equal-priority offer in fetch
    cur_req = "R6";
    pulse(1, 50, 6, 0);
    cyc1(); cyc1();
    pulse(1, 51, 3, 0);
    chk("R6 cyc unchanged", int'(cyc_o), 4);
    chk("R6 vec swapped", int'(vec_num_o), 51);
    chk("R6 still stacking", int'(state_o), 1);
    wait_st(2);
    cur_req = "R7";
    pulse(1, 52, 3, 0);
    chk("R7 equal prio ignored", int'(vec_num_o), 51);
    wait_st(3);
    cur_req = "R8";
    pulse(0, 0, 0, 1);
    chk("R8 chain state", int'(state_o), 5);
    chk("R8 displaced target", int'(vec_num_o), 50);
    wait_st(3);
    cur_req = "R4";
    pulse(0, 0, 0, 1);
    wait_st(0);

    // late arrival during fetch, return with more urgent offer
    cur_req = "R6";
    pulse(1, 60, 8, 0);
    wait_st(2);
    pulse(1, 61, 2, 0);
    chk("R6 fetch swap", int'(vec_num_o), 61);
    wait_st(3);
    cur_req = "R8";
    pulse(1, 62, 1, 1);
    chk("R8 urgent offer wins", int'(vec_num_o), 62);
    wait_st(3);
    cur_req = "R5";
    pulse(1, 60, 8, 1);
    chk("R5 new target", int'(vec_num_o), 60);
    span(5, 5, n, np, npo, nb);
    chk("R5 tail cycles", n, 6);
    chk("R5 no beats", np + npo + nb, 0);
    chk("R5 run after", int'(state_o), 3);
    cur_req = "R4";
    pulse(0, 0, 0, 1);
    wait_st(0);

    // preemption and nested return
    cur_req = "R9";
    pulse(1, 70, 10, 0);
    wait_st(3);
    pulse(1, 71, 4, 0);
    chk("R9 preempt stacking", int'(state_o), 1);
    chk("R9 preempt target", int'(vec_num_o), 71);
    cur_req = "R11";
    pulse(0, 0, 0, 1);
    chk("R11 ret in stacking", int'(state_o), 1);
    chk("R11 cyc after ret", int'(cyc_o), 2);
    wait_st(3);
    cur_req = "R10";
    pulse(1, 72, 12, 1);
    chk("R10 no chain", int'(state_o), 4);
    cur_req = "R11";
    pulse(1, 73, 0, 0);
    chk("R11 take in unstack", int'(state_o), 4);
    cur_req = "R9";
    wait_st(3);
    chk("R9 resumed", int'(vec_num_o), 70);
    cur_req = "R5";
    pulse(1, 74, 1, 1);
    chk("R5 chain from resumed", int'(vec_num_o), 74);
    cur_req = "R11";
    pulse(1, 75, 0, 0);
    chk("R11 take in tail", int'(vec_num_o), 74);
    chk("R11 tail state", int'(state_o), 5);
    wait_st(3);
    cur_req = "R4";
    pulse(0, 0, 0, 1);
    wait_st(0);
    cyc1(); cyc1();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule